// File: doc/BRIEF.md
# Triggered Pulse Charge Integrator with Baseline Removal

This block measures the charge in one digitized beam pulse. Software arms it first. The next external sync trigger then starts a fixed sequence. The block sums a baseline window of samples taken before the pulse. It skips an optional gap and then sums a beam window of preset length. The block reports the beam sum minus the baseline sum, raises a one-cycle done strobe and goes back to idle. It accepts no further trigger until software arms it again.

During the beam window the block also emits a waveform stream for a memory writer. The baseline length is a power of two, so the baseline mean is the baseline sum shifted right. The block subtracts this mean from each beam sample. The corrected stream can be thinned to one sample in every D.

Only samples flagged valid count toward any window. The window lengths, the gap and the thinning factor are configuration inputs. The block reads them while a sequence runs.

Top module: `pulse_charge_seq`

## Requirements
- R1: After reset the block is idle and unarmed: busy, armed, done and w_vld are 0 and result is 0.
- R2: A trigger seen while the block is idle but not armed is ignored, and busy stays 0.
- R3: An arm pulse sets armed. An accepted trigger makes busy 1 and clears armed on the same edge. A trigger that arrives while a sequence runs has no effect on it.
- R4: The baseline window covers 2^cfg_base_log2 valid samples. It starts with the first valid sample after the clock edge that accepted the trigger.
- R5: After the baseline window the block skips cfg_gap valid samples. It then sums cfg_beam_len valid samples, where 0 is taken as 1. A sample with s_vld low counts toward no window.
- R6: One cycle after the clock edge that takes the last beam sample, done is high for exactly one cycle. At the same time result holds the beam sum minus the baseline sum as a signed value, and busy is 0.
- R7: result keeps its value until the next sequence completes.
- R8: For each beam-window sample that is kept, w_vld is high one cycle later. w_data then equals the sample minus floor(baseline sum / 2^cfg_base_log2), as a signed SW+1-bit value. w_vld is low at every other time.
- R9: The first beam sample is always kept. After it, every cfg_decim-th beam sample is kept. A cfg_decim of 0 or 1 keeps every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Software arm pulse |
| trig | input | 1 | External beam sync trigger |
| s_vld | input | 1 | Sample valid |
| s_data | input | SW | Signed two's-complement sample |
| cfg_base_log2 | input | LOG_W | log2 of the baseline window length |
| cfg_gap | input | CNT_W | Valid samples skipped between the windows |
| cfg_beam_len | input | CNT_W | Beam window length in valid samples |
| cfg_decim | input | DEC_W | Decimation factor D |
| busy | output | 1 | A sequence is running |
| armed | output | 1 | A trigger will be accepted |
| done | output | 1 | One-cycle completion strobe |
| result | output | res_w(SW,CNT_W,LOG_W) | Signed beam sum minus baseline sum |
| w_vld | output | 1 | Corrected waveform sample valid |
| w_data | output | SW+1 | Signed baseline-corrected sample |

## Verification
A window counter that is off by one shifts samples from one phase into the next. This changes result and moves done by one sample, and both appear in the cycle after the last beam sample. A wrong baseline sum or a wrong mean shift already shows on the first corrected sample of the beam window, long before result comes out. A stale decimation count or a stuck armed flag shows on the next kept sample or the next trigger.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BASE = 2'd1,
        ST_GAP  = 2'd2,
        ST_BEAM = 2'd3
    } pcs_state_t;

    function automatic int base_w(input int sw, input int log_w);
        return sw + (2 ** log_w) - 1;
    endfunction

    function automatic int res_w(input int sw, input int cnt_w, input int log_w);
        int bw;
        int mw;
        bw = base_w(sw, log_w);
        mw = (bw > sw + cnt_w) ? bw : sw + cnt_w;
        return mw + 1;
    endfunction

endpackage

// File: rtl/pcs_window_acc.sv
module pcs_window_acc #(
    parameter int SW = 16,
    parameter int W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                add,
    input  logic signed [SW-1:0] din,
    output logic signed [W-1:0] sum_q,
    output logic signed [W-1:0] sum_nx
);

    logic signed [W-1:0] sum_d;

    always_comb begin
        sum_nx = add ? (sum_q + W'(din)) : sum_q;
        sum_d  = clr ? '0 : sum_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum_q == '0)); // R4

endmodule

// File: rtl/pcs_decim.sv
module pcs_decim #(
    parameter int DEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [DEC_W-1:0] factor,
    output logic             keep
);

    logic [DEC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        keep  = (cnt_q == '0);
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (step) begin
            if (factor <= DEC_W'(1) || cnt_q == factor - DEC_W'(1)) cnt_d = '0;
            else                                                    cnt_d = cnt_q + DEC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_DEC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> keep); // R9

endmodule

// File: rtl/pulse_charge_seq.sv
module pulse_charge_seq
    import pcs_pkg::*;
#(
    parameter int SW    = 16,
    parameter int CNT_W = 16,
    parameter int LOG_W = 4,
    parameter int DEC_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 arm,
    input  logic                                 trig,
    input  logic                                 s_vld,
    input  logic [SW-1:0]                        s_data,
    input  logic [LOG_W-1:0]                     cfg_base_log2,
    input  logic [CNT_W-1:0]                     cfg_gap,
    input  logic [CNT_W-1:0]                     cfg_beam_len,
    input  logic [DEC_W-1:0]                     cfg_decim,
    output logic                                 busy,
    output logic                                 armed,
    output logic                                 done,
    output logic [res_w(SW,CNT_W,LOG_W)-1:0]     result,
    output logic                                 w_vld,
    output logic [SW:0]                          w_data
);

    localparam int BASE_W = base_w(SW, LOG_W);
    localparam int BEAM_W = SW + CNT_W;
    localparam int ACC_W  = res_w(SW, CNT_W, LOG_W);
    localparam int CW     = (CNT_W > (2 ** LOG_W)) ? CNT_W : (2 ** LOG_W);

    typedef struct packed {
        pcs_state_t              st;
        logic                    armed;
        logic [CW-1:0]           cnt;
        logic                    done;
        logic signed [ACC_W-1:0] res;
        logic                    wv;
        logic signed [SW:0]      wd;
    } seq_t;

    seq_t q, d;

    logic signed [SW-1:0]     smp;
    logic                     start;
    logic                     base_add;
    logic                     beam_add;
    logic                     keep;
    logic signed [BASE_W-1:0] base_sum_q;
    logic signed [BASE_W-1:0] base_sum_nx;
    logic signed [BEAM_W-1:0] beam_sum_q;
    logic signed [BEAM_W-1:0] beam_sum_nx;
    logic signed [ACC_W-1:0]  mean;
    logic signed [ACC_W-1:0]  diff_full;
    logic [CW-1:0]            base_last;
    logic [CW-1:0]            gap_last;
    logic [CW-1:0]            beam_last;

    assign smp      = $signed(s_data);
    assign start    = (q.st == ST_IDLE) && q.armed && trig;
    assign base_add = (q.st == ST_BASE) && s_vld;
    assign beam_add = (q.st == ST_BEAM) && s_vld;

    pcs_window_acc #(.SW(SW), .W(BASE_W)) u_base_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .add    (base_add),
        .din    (smp),
        .sum_q  (base_sum_q),
        .sum_nx (base_sum_nx)
    );

    pcs_window_acc #(.SW(SW), .W(BEAM_W)) u_beam_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .add    (beam_add),
        .din    (smp),
        .sum_q  (beam_sum_q),
        .sum_nx (beam_sum_nx)
    );

    pcs_decim #(.DEC_W(DEC_W)) u_decim (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .step    (beam_add),
        .factor  (cfg_decim),
        .keep    (keep)
    );

    always_comb begin
        base_last = (CW'(1) << cfg_base_log2) - CW'(1);
        gap_last  = CW'(cfg_gap) - CW'(1);
        beam_last = (cfg_beam_len == '0) ? '0 : CW'(cfg_beam_len) - CW'(1);
        mean      = ACC_W'(base_sum_q >>> cfg_base_log2);
        diff_full = ACC_W'(smp) - mean;

        d      = q;
        d.done = 1'b0;
        d.wv   = 1'b0;
        if (arm) d.armed = 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.armed = 1'b0;
                    d.st    = ST_BASE;
                    d.cnt   = '0;
                end
            end
            ST_BASE: begin
                if (s_vld) begin
                    if (q.cnt == base_last) begin
                        d.cnt = '0;
                        d.st  = (cfg_gap == '0) ? ST_BEAM : ST_GAP;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            ST_GAP: begin
                if (s_vld) begin
                    if (q.cnt == gap_last) begin
                        d.cnt = '0;
                        d.st  = ST_BEAM;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            ST_BEAM: begin
                if (s_vld) begin
                    if (keep) begin
                        d.wv = 1'b1;
                        d.wd = diff_full[SW:0];
                    end
                    if (q.cnt == beam_last) begin
                        d.cnt  = '0;
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.res  = ACC_W'(beam_sum_nx) - ACC_W'(base_sum_q);
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.armed <= 1'b0;
            q.cnt   <= '0;
            q.done  <= 1'b0;
            q.res   <= '0;
            q.wv    <= 1'b0;
            q.wd    <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy   = (q.st != ST_IDLE);
    assign armed  = q.armed;
    assign done   = q.done;
    assign result = q.res;
    assign w_vld  = q.wv;
    assign w_data = q.wd;

    AST_NO_START_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !q.armed) |=> (q.st == ST_IDLE)); // R2

    AST_START_CLEARS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && q.armed && trig) |=> (q.st == ST_BASE && !q.armed)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !$past(done))); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R7

    AST_WOUT_IN_BEAM: assert property (@(posedge clk) disable iff (!rst_n)
        w_vld |-> $past(q.st == ST_BEAM && s_vld)); // R8

endmodule

// File: tb/tb_pulse_charge_seq.sv
module tb_pulse_charge_seq;
    import pcs_pkg::*;

    localparam int SW    = 16;
    localparam int CNT_W = 16;
    localparam int LOG_W = 4;
    localparam int DEC_W = 8;
    localparam int RW    = res_w(SW, CNT_W, LOG_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arm = 1'b0;
    logic              trig = 1'b0;
    logic              s_vld = 1'b0;
    logic [SW-1:0]     s_data = '0;
    logic [LOG_W-1:0]  cfg_base_log2 = '0;
    logic [CNT_W-1:0]  cfg_gap = '0;
    logic [CNT_W-1:0]  cfg_beam_len = '0;
    logic [DEC_W-1:0]  cfg_decim = '0;
    logic              busy, armed, done, w_vld;
    logic [RW-1:0]     result;
    logic [SW:0]       w_data;

    int checks = 0;
    int errors = 0;
    longint last_result = 0;

    always #2.5 clk = ~clk;

    pulse_charge_seq #(.SW(SW), .CNT_W(CNT_W), .LOG_W(LOG_W), .DEC_W(DEC_W)) dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .s_vld(s_vld), .s_data(s_data),
        .cfg_base_log2(cfg_base_log2), .cfg_gap(cfg_gap), .cfg_beam_len(cfg_beam_len),
        .cfg_decim(cfg_decim), .busy(busy), .armed(armed), .done(done), .result(result),
        .w_vld(w_vld), .w_data(w_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int smp_val(input int i, input int seed, input int lvl);
        return ((i * 29 + seed * 7) % 61) - 30 + lvl;
    endfunction

    task automatic test_reset();
        check(busy == 0 && armed == 0, "R1", "busy/armed after reset", {busy, armed}, 0);
        check(done == 0 && w_vld == 0, "R1", "done/w_vld after reset", {done, w_vld}, 0);
        check($signed(result) == 0, "R1", "result after reset", $signed(result), 0);
    endtask

    task automatic test_unarmed_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        check(busy == 0, "R2", "busy after unarmed trigger", busy, 0);
        @(negedge clk);
        check(busy == 0 && armed == 0, "R2", "still idle", {busy, armed}, 0);
    endtask

    // Full sequence: baseline at level blvl, beam at level plvl.
    task automatic run_seq(input int lg, input int gap, input int blen, input int dec,
                           input int seed, input int blvl, input int plvl,
                           input bit holes, input bit noise_trig);
        int nb, eff_len, total, j;
        longint bsum, psum, mean, expd;
        nb = 1 << lg;
        eff_len = (blen == 0) ? 1 : blen;
        total = nb + gap + eff_len;
        bsum = 0; psum = 0;
        cfg_base_log2 = LOG_W'(lg);
        cfg_gap = CNT_W'(gap);
        cfg_beam_len = CNT_W'(blen);
        cfg_decim = DEC_W'(dec);
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        check(armed == 1, "R3", "armed after arm pulse", armed, 1);
        trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        check(busy == 1 && armed == 0, "R3", "busy set, armed cleared", {busy, armed}, 2);
        for (int i = 0; i < total; i++) begin
            int v;
            bit in_beam;
            if (holes && (i % 3 == 1)) begin
                s_vld = 1'b0; s_data = 16'h7ABC;
                @(negedge clk);
                check(w_vld == 0 && done == 0, "R5", "invalid sample ignored", {w_vld, done}, 0);
            end
            in_beam = (i >= nb + gap);
            v = smp_val(i, seed, in_beam ? plvl : blvl);
            if (i < nb) bsum += v;
            if (in_beam) psum += v;
            s_vld = 1'b1; s_data = SW'(v);
            if (noise_trig && i == 0) trig = 1'b1;
            @(negedge clk);
            trig = 1'b0; s_vld = 1'b0;
            if (in_beam) begin
                j = i - nb - gap;
                mean = bsum >>> lg;
                expd = v - mean;
                if (dec <= 1 || (j % dec) == 0) begin
                    check(w_vld == 1, (dec > 1) ? "R9" : "R8", "kept sample valid", w_vld, 1);
                    check($signed(w_data) == expd, "R8", "corrected sample", $signed(w_data), expd);
                end else begin
                    check(w_vld == 0, "R9", "decimated sample dropped", w_vld, 0);
                end
            end else begin
                check(w_vld == 0, "R4", "no output outside beam window", w_vld, 0);
            end
            if (i == total - 1) begin
                check(done == 1, "R6", "done after last beam sample", done, 1);
                check($signed(result) == psum - bsum, "R6", "beam minus baseline",
                      $signed(result), psum - bsum);
                check(busy == 0, "R6", "idle after done", busy, 0);
                last_result = psum - bsum;
            end else begin
                check(done == 0, "R5", "no early done", done, 0);
            end
        end
        @(negedge clk);
        check(done == 0, "R6", "done lasts one cycle", done, 0);
        check(armed == (noise_trig ? 0 : 0), "R3", "armed stays clear after run", armed, 0);
    endtask

    task automatic test_hold();
        for (int k = 0; k < 6; k++) begin
            s_vld = 1'b1; s_data = SW'(1000 + k);
            trig = (k == 2);
            @(negedge clk);
        end
        s_vld = 1'b0; trig = 1'b0;
        check($signed(result) == last_result, "R7", "result held", $signed(result), last_result);
        check(done == 0 && busy == 0, "R2", "trigger after run ignored without arm", {done, busy}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_unarmed_trig();
        run_seq(2, 0, 5, 1, 1, 40, 900, 1'b0, 1'b0);     // R4 R5 R8
        test_hold();                                      // R7
        run_seq(3, 4, 10, 3, 5, -70, 300, 1'b1, 1'b0);   // R5 R9 negative baseline
        run_seq(0, 2, 0, 0, 9, 12, -500, 1'b0, 1'b1);    // R3 mid-run trigger, R5 len 0
        run_seq(4, 1, 7, 2, 3, -5, 20, 1'b1, 1'b0);      // R9
        test_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule